// File: doc/BRIEF.md
# Error Signaling Gate for a Serial-Link Function

This block decides, for a single detected error in one function of a serial interconnect device, which status bits to set, whether the error header must be recorded, and whether an error message goes upstream and at what severity. An error arrives as a one-cycle strobe together with a one-hot error bit, a flag that marks it correctable or uncorrectable, a flag that permits an advisory downgrade, and a flag that marks it as an unsupported request. The mask, severity, device-control and command enables are static inputs that are sampled with the strobe. The device status bits and the correctable and uncorrectable status vectors stay set until reset. The record request, the message strobe, its severity and its source identifier appear one cycle after the error strobe.

A second, independent gate models one upstream bridge hop. An incoming message that is not correctable sets the bridge's received-system-error flag. Any incoming message is passed on one cycle later only when the bridge's system-error forwarding enable is set. The header store and the message transport are outside the block.

Top module: `aer_signal_gate`

## Requirements
- R1: After reset, every status output, `log_req`, `msg_valid`, `sec_rcv_serr` and `hop_out_valid` are zero.
- R2: A strobe whose `err_status` is zero or has more than one bit set is ignored: no status bit changes and neither a record request nor a message follows.
- R3: A correctable error sets `dev_status[0]` (correctable detected) and its own bit in `cor_status`. If that bit is set in `cor_mask`, no message follows.
- R4: An unmasked correctable error sends a message of severity 0 (correctable) only when `ctl_cor_en` is set. A correctable error never requests a record.
- R5: For an uncorrectable error, the severity is fatal when the matching `uncor_sev` bit is set and non-fatal otherwise. A fatal error sets `dev_status[2]` and a non-fatal one sets `dev_status[1]`. Any error flagged unsupported-request that is not correctable sets `dev_status[3]`. Message severity codes are 1 for non-fatal and 2 for fatal.
- R6: An uncorrectable error always sets its `uncor_status` bit. When its `uncor_mask` bit is set, no record and no message follow. When the mask bit is clear, `log_req` pulses.
- R7: An unmasked fatal error is sent only if `cmd_serr_en` or `ctl_fatal_en` is set. An unmasked non-fatal error is sent only if `cmd_serr_en` or `ctl_nonfatal_en` is set.
- R8: An unsupported-request error is not sent when both `ctl_ur_en` and `cmd_serr_en` are clear, even if the severity enable is set.
- R9: A non-fatal error with `err_advisory` set is handled as correctable. It sets `dev_status[0]` (and `dev_status[3]` if it is an unsupported request) and sets `cor_status` bit ADV_BIT (default 13). If `cor_mask[ADV_BIT]` is set, nothing further happens. Otherwise its `uncor_status` bit is set, a record is requested only if its `uncor_mask` bit is clear, and a severity-0 message is sent if `ctl_cor_en` is set and, for an unsupported request, `ctl_ur_en` is set. A fatal error with `err_advisory` set follows R5 to R8.
- R10: `msg_src` equals `bus_num` shifted left by 8, ORed with `devfn`, captured with the error.
- R11: `log_req` and `msg_valid` go high exactly one cycle after the strobe and stay high for that single cycle.
- R12: A hop message whose `hop_in_sev` is not 0 sets `sec_rcv_serr`. One cycle after any hop message, `hop_out_valid` pulses with the same severity and source if `bridge_serr_en` is set, and stays low otherwise.
- R13: Status bits in `dev_status`, `cor_status`, `uncor_status` and `sec_rcv_serr` are never cleared except by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_valid | input | 1 | One-cycle error strobe |
| err_status | input | ERR_W | One-hot error bit |
| err_is_cor | input | 1 | Error is correctable |
| err_advisory | input | 1 | Non-fatal error may be downgraded to advisory |
| err_is_ur | input | 1 | Error is an unsupported request |
| cor_mask | input | ERR_W | Correctable mask |
| uncor_mask | input | ERR_W | Uncorrectable mask |
| uncor_sev | input | ERR_W | Uncorrectable severity (1 = fatal) |
| cmd_serr_en | input | 1 | Command system-error enable |
| ctl_cor_en | input | 1 | Correctable reporting enable |
| ctl_nonfatal_en | input | 1 | Non-fatal reporting enable |
| ctl_fatal_en | input | 1 | Fatal reporting enable |
| ctl_ur_en | input | 1 | Unsupported-request reporting enable |
| bus_num | input | BUS_W | Bus number |
| devfn | input | FN_W | Device/function number |
| hop_in_valid | input | 1 | Message arriving at bridge hop |
| hop_in_sev | input | 2 | Its severity |
| hop_in_src | input | BUS_W+FN_W | Its source identifier |
| bridge_serr_en | input | 1 | Bridge forwarding enable |
| dev_status | output | 4 | Detected bits: correctable, non-fatal, fatal, unsupported request |
| cor_status | output | ERR_W | Correctable status |
| uncor_status | output | ERR_W | Uncorrectable status |
| log_req | output | 1 | Record request pulse |
| msg_valid | output | 1 | Message pulse |
| msg_sev | output | 2 | Message severity |
| msg_src | output | BUS_W+FN_W | Message source identifier |
| sec_rcv_serr | output | 1 | Bridge received system error |
| hop_out_valid | output | 1 | Forwarded message pulse |
| hop_out_sev | output | 2 | Forwarded severity |
| hop_out_src | output | BUS_W+FN_W | Forwarded source identifier |

## Verification
The function's own error path and the bridge hop can act in the same cycle: an error strobe can meet an incoming hop message, and both then drive registered outputs at the same clock edge. The bench drives a correctable error and a fatal hop message on one edge, with forwarding enabled. It then expects `msg_valid` with severity 0 and `hop_out_valid` with severity 2 together one cycle later, `sec_rcv_serr` set, and the correctable status bit added without disturbing the bits set earlier.

// File: rtl/aer_gate_pkg.sv
package aer_gate_pkg;
  typedef enum logic [1:0] {
    SEV_COR      = 2'd0,
    SEV_NONFATAL = 2'd1,
    SEV_FATAL    = 2'd2
  } sev_e;

  typedef struct packed {
    logic ur;
    logic fatal;
    logic nonfatal;
    logic cor;
  } devsta_t;
endpackage

// File: rtl/aer_rst_sync.sv
module aer_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/aer_err_classify.sv
module aer_err_classify
  import aer_gate_pkg::*;
#(
  parameter int ERR_W   = 32,
  parameter int ADV_BIT = 13
) (
  input  logic             err_valid,
  input  logic [ERR_W-1:0] err_status,
  input  logic             err_is_cor,
  input  logic             err_advisory,
  input  logic             err_is_ur,
  input  logic [ERR_W-1:0] cor_mask,
  input  logic [ERR_W-1:0] uncor_mask,
  input  logic [ERR_W-1:0] uncor_sev,
  input  logic             cmd_serr_en,
  input  logic             ctl_cor_en,
  input  logic             ctl_nonfatal_en,
  input  logic             ctl_fatal_en,
  input  logic             ctl_ur_en,
  output logic [ERR_W-1:0] set_cor,
  output logic [ERR_W-1:0] set_uncor,
  output devsta_t          set_dev,
  output logic             do_log,
  output logic             do_msg,
  output sev_e             msg_sev
);
  localparam logic [ERR_W-1:0] ADV_ONEHOT = ERR_W'(1) << ADV_BIT;

  logic one_hot;
  logic evt;
  logic is_fatal;
  logic cmask_hit;
  logic umask_hit;
  logic ur_blocked;

  always_comb begin
    one_hot    = (err_status != '0) && ((err_status & (err_status - ERR_W'(1))) == '0);
    evt        = err_valid && one_hot;
    is_fatal   = |(err_status & uncor_sev);
    cmask_hit  = |(err_status & cor_mask);
    umask_hit  = |(err_status & uncor_mask);
    ur_blocked = err_is_ur && !ctl_ur_en && !cmd_serr_en;

    set_cor   = '0;
    set_uncor = '0;
    set_dev   = '0;
    do_log    = 1'b0;
    do_msg    = 1'b0;
    msg_sev   = SEV_COR;

    if (evt) begin
      if (err_is_cor) begin
        set_dev.cor = 1'b1;
        set_cor     = err_status;
        if (!cmask_hit) begin
          do_msg  = ctl_cor_en;
          msg_sev = SEV_COR;
        end
      end else if (err_advisory && !is_fatal) begin
        set_dev.cor = 1'b1;
        set_dev.ur  = err_is_ur;
        set_cor     = ADV_ONEHOT;
        if (!cor_mask[ADV_BIT]) begin
          set_uncor = err_status;
          do_log    = !umask_hit;
          do_msg    = ctl_cor_en && (!err_is_ur || ctl_ur_en);
          msg_sev   = SEV_COR;
        end
      end else begin
        set_dev.fatal    = is_fatal;
        set_dev.nonfatal = !is_fatal;
        set_dev.ur       = err_is_ur;
        set_uncor        = err_status;
        if (!umask_hit) begin
          do_log = 1'b1;
          if (ur_blocked) begin
            do_msg = 1'b0;
          end else if (is_fatal) begin
            do_msg  = cmd_serr_en || ctl_fatal_en;
            msg_sev = SEV_FATAL;
          end else begin
            do_msg  = cmd_serr_en || ctl_nonfatal_en;
            msg_sev = SEV_NONFATAL;
          end
        end
      end
    end
  end
endmodule

// File: rtl/aer_sticky_bits.sv
module aer_sticky_bits #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set,
  output logic [W-1:0] q
);
  logic         upd;
  logic [W-1:0] nxt;

  always_comb begin
    upd = |set;
    nxt = q | set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= nxt;
  end
endmodule

// File: rtl/aer_hop_gate.sv
module aer_hop_gate
  import aer_gate_pkg::*;
#(
  parameter int SRC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [1:0]       in_sev,
  input  logic [SRC_W-1:0] in_src,
  input  logic             serr_fwd_en,
  output logic             rcv_serr,
  output logic             out_valid,
  output logic [1:0]       out_sev,
  output logic [SRC_W-1:0] out_src
);
  logic             rcv_d;
  logic             rcv_en;
  logic             fwd_d;

  always_comb begin
    rcv_en = in_valid && (in_sev != SEV_COR);
    rcv_d  = rcv_serr | rcv_en;
    fwd_d  = in_valid && serr_fwd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rcv_serr  <= 1'b0;
      out_valid <= 1'b0;
      out_sev   <= 2'd0;
      out_src   <= '0;
    end else begin
      out_valid <= fwd_d;
      if (rcv_en) rcv_serr <= rcv_d;
      if (fwd_d) begin
        out_sev <= in_sev;
        out_src <= in_src;
      end
    end
  end
endmodule

// File: rtl/aer_signal_gate.sv
module aer_signal_gate
  import aer_gate_pkg::*;
#(
  parameter int ERR_W   = 32,
  parameter int ADV_BIT = 13,
  parameter int BUS_W   = 8,
  parameter int FN_W    = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  err_valid,
  input  logic [ERR_W-1:0]      err_status,
  input  logic                  err_is_cor,
  input  logic                  err_advisory,
  input  logic                  err_is_ur,
  input  logic [ERR_W-1:0]      cor_mask,
  input  logic [ERR_W-1:0]      uncor_mask,
  input  logic [ERR_W-1:0]      uncor_sev,
  input  logic                  cmd_serr_en,
  input  logic                  ctl_cor_en,
  input  logic                  ctl_nonfatal_en,
  input  logic                  ctl_fatal_en,
  input  logic                  ctl_ur_en,
  input  logic [BUS_W-1:0]      bus_num,
  input  logic [FN_W-1:0]       devfn,
  input  logic                  hop_in_valid,
  input  logic [1:0]            hop_in_sev,
  input  logic [BUS_W+FN_W-1:0] hop_in_src,
  input  logic                  bridge_serr_en,
  output logic [3:0]            dev_status,
  output logic [ERR_W-1:0]      cor_status,
  output logic [ERR_W-1:0]      uncor_status,
  output logic                  log_req,
  output logic                  msg_valid,
  output logic [1:0]            msg_sev,
  output logic [BUS_W+FN_W-1:0] msg_src,
  output logic                  sec_rcv_serr,
  output logic                  hop_out_valid,
  output logic [1:0]            hop_out_sev,
  output logic [BUS_W+FN_W-1:0] hop_out_src
);
  localparam int SRC_W = BUS_W + FN_W;

  logic             rst_n_int;
  logic [ERR_W-1:0] set_cor;
  logic [ERR_W-1:0] set_uncor;
  devsta_t          set_dev;
  logic             do_log;
  logic             do_msg;
  sev_e             nxt_sev;
  logic [SRC_W-1:0] src_id;

  aer_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  aer_err_classify #(.ERR_W(ERR_W), .ADV_BIT(ADV_BIT)) u_cls (
    .err_valid       (err_valid),
    .err_status      (err_status),
    .err_is_cor      (err_is_cor),
    .err_advisory    (err_advisory),
    .err_is_ur       (err_is_ur),
    .cor_mask        (cor_mask),
    .uncor_mask      (uncor_mask),
    .uncor_sev       (uncor_sev),
    .cmd_serr_en     (cmd_serr_en),
    .ctl_cor_en      (ctl_cor_en),
    .ctl_nonfatal_en (ctl_nonfatal_en),
    .ctl_fatal_en    (ctl_fatal_en),
    .ctl_ur_en       (ctl_ur_en),
    .set_cor         (set_cor),
    .set_uncor       (set_uncor),
    .set_dev         (set_dev),
    .do_log          (do_log),
    .do_msg          (do_msg),
    .msg_sev         (nxt_sev)
  );

  aer_sticky_bits #(.W(ERR_W)) u_cor_sta (
    .clk (clk), .rst_n (rst_n_int), .set (set_cor), .q (cor_status)
  );

  aer_sticky_bits #(.W(ERR_W)) u_unc_sta (
    .clk (clk), .rst_n (rst_n_int), .set (set_uncor), .q (uncor_status)
  );

  aer_sticky_bits #(.W(4)) u_dev_sta (
    .clk (clk), .rst_n (rst_n_int), .set (set_dev), .q (dev_status)
  );

  aer_hop_gate #(.SRC_W(SRC_W)) u_hop (
    .clk         (clk),
    .rst_n       (rst_n_int),
    .in_valid    (hop_in_valid),
    .in_sev      (hop_in_sev),
    .in_src      (hop_in_src),
    .serr_fwd_en (bridge_serr_en),
    .rcv_serr    (sec_rcv_serr),
    .out_valid   (hop_out_valid),
    .out_sev     (hop_out_sev),
    .out_src     (hop_out_src)
  );

  always_comb begin
    src_id = (SRC_W'(bus_num) << FN_W) | SRC_W'(devfn);
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      log_req   <= 1'b0;
      msg_valid <= 1'b0;
      msg_sev   <= 2'd0;
      msg_src   <= '0;
    end else begin
      log_req   <= do_log;
      msg_valid <= do_msg;
      if (do_msg) begin
        msg_sev <= nxt_sev;
        msg_src <= src_id;
      end
    end
  end
endmodule

// File: rtl/aer_signal_gate_chk.sv
module aer_signal_gate_chk #(
  parameter int ERR_W = 32,
  parameter int SRC_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             err_valid,
  input logic [ERR_W-1:0] err_status,
  input logic [ERR_W-1:0] uncor_mask,
  input logic             cmd_serr_en,
  input logic             ctl_cor_en,
  input logic             ctl_fatal_en,
  input logic             hop_in_valid,
  input logic [1:0]       hop_in_sev,
  input logic             bridge_serr_en,
  input logic [ERR_W-1:0] cor_status,
  input logic [ERR_W-1:0] uncor_status,
  input logic             log_req,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic             sec_rcv_serr,
  input logic             hop_out_valid
);
  a_r11_log_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $past(err_valid));
  a_r11_msg_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> $past(err_valid));
  a_r6_log_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
    log_req |-> $past((err_status & uncor_mask) == '0));
  a_r7_fatal_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd2) |-> $past(cmd_serr_en || ctl_fatal_en));
  a_r4_cor_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd0) |-> $past(ctl_cor_en));
  a_r5_sev_legal: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid |-> (msg_sev != 2'd3));
  a_r13_cor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cor_status & $past(cor_status)) == $past(cor_status));
  a_r13_uncor_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (uncor_status & $past(uncor_status)) == $past(uncor_status));
  a_r12_fwd_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    hop_out_valid |-> $past(hop_in_valid && bridge_serr_en));
  a_r12_rcv_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sec_rcv_serr) |-> $past(hop_in_valid && hop_in_sev != 2'd0));
endmodule

bind aer_signal_gate aer_signal_gate_chk #(.ERR_W(ERR_W), .SRC_W(BUS_W + FN_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .err_valid      (err_valid),
  .err_status     (err_status),
  .uncor_mask     (uncor_mask),
  .cmd_serr_en    (cmd_serr_en),
  .ctl_cor_en     (ctl_cor_en),
  .ctl_fatal_en   (ctl_fatal_en),
  .hop_in_valid   (hop_in_valid),
  .hop_in_sev     (hop_in_sev),
  .bridge_serr_en (bridge_serr_en),
  .cor_status     (cor_status),
  .uncor_status   (uncor_status),
  .log_req        (log_req),
  .msg_valid      (msg_valid),
  .msg_sev        (msg_sev),
  .sec_rcv_serr   (sec_rcv_serr),
  .hop_out_valid  (hop_out_valid)
);

// File: tb/test_aer_signal_gate.sv
module test_aer_signal_gate;
  localparam int ERR_W = 32;
  localparam int ADV   = 13;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, err_valid, err_is_cor, err_advisory, err_is_ur;
  logic [ERR_W-1:0] err_status, cor_mask, uncor_mask, uncor_sev;
  logic cmd_serr_en, ctl_cor_en, ctl_nonfatal_en, ctl_fatal_en, ctl_ur_en;
  logic [7:0] bus_num, devfn;
  logic hop_in_valid, bridge_serr_en;
  logic [1:0] hop_in_sev;
  logic [15:0] hop_in_src;
  logic [3:0] dev_status;
  logic [ERR_W-1:0] cor_status, uncor_status;
  logic log_req, msg_valid, sec_rcv_serr, hop_out_valid;
  logic [1:0] msg_sev, hop_out_sev;
  logic [15:0] msg_src, hop_out_src;

  aer_signal_gate i_aer_signal_gate (.*);

  typedef struct packed {
    logic [4:0] idx;
    logic cor, adv, ur, cm, um, sv, ce, ne, fe, ue, se;
    logic x_cor, x_adv, x_unc;
    logic [3:0] x_dev;
    logic x_log, x_msg;
    logic [1:0] x_sev;
  } vec_t;

  localparam int NV = 18;
  localparam vec_t VECS [NV] = '{
    '{5'd0, 1,0,0, 0,0,0, 1,0,0,0,0, 1,0,0, 4'b0001, 0,1, 2'd0}, // R3 R4 unmasked cor sent
    '{5'd6, 1,0,0, 1,0,0, 1,0,0,0,0, 1,0,0, 4'b0001, 0,0, 2'd0}, // R3 masked cor silent
    '{5'd7, 1,0,0, 0,0,0, 0,1,1,1,1, 1,0,0, 4'b0001, 0,0, 2'd0}, // R4 cor enable clear
    '{5'd4, 0,0,0, 0,0,1, 0,0,1,0,0, 0,0,1, 4'b0100, 1,1, 2'd2}, // R5 R7 fatal via fatal enable
    '{5'd5, 0,0,0, 0,0,1, 0,1,0,0,0, 0,0,1, 4'b0100, 1,0, 2'd0}, // R7 fatal, only nonfatal enable
    '{5'd12,0,0,0, 0,0,1, 0,0,0,0,1, 0,0,1, 4'b0100, 1,1, 2'd2}, // R7 fatal via SERR
    '{5'd14,0,0,0, 0,0,0, 0,1,0,0,0, 0,0,1, 4'b0010, 1,1, 2'd1}, // R5 nonfatal sent
    '{5'd16,0,0,0, 0,0,0, 1,0,1,1,0, 0,0,1, 4'b0010, 1,0, 2'd0}, // R7 nonfatal, no enable
    '{5'd18,0,0,0, 0,1,0, 1,1,1,1,1, 0,0,1, 4'b0010, 0,0, 2'd0}, // R6 masked uncor
    '{5'd20,0,0,1, 0,0,0, 1,1,1,0,0, 0,0,1, 4'b1010, 1,0, 2'd0}, // R8 UR blocked
    '{5'd20,0,0,1, 0,0,0, 0,1,0,1,0, 0,0,1, 4'b1010, 1,1, 2'd1}, // R8 UR enable
    '{5'd20,0,0,1, 0,0,0, 0,0,0,0,1, 0,0,1, 4'b1010, 1,1, 2'd1}, // R8 SERR carries UR
    '{5'd21,0,1,0, 0,0,0, 1,0,0,0,0, 0,1,1, 4'b0001, 1,1, 2'd0}, // R9 advisory logged
    '{5'd22,0,1,0, 0,1,0, 1,0,0,0,0, 0,1,1, 4'b0001, 0,1, 2'd0}, // R9 advisory uncor-masked
    '{5'd23,0,1,0, 1,0,0, 1,1,1,1,1, 0,1,0, 4'b0001, 0,0, 2'd0}, // R9 advisory cor-masked
    '{5'd24,0,1,0, 0,0,0, 0,1,1,1,1, 0,1,1, 4'b0001, 1,0, 2'd0}, // R9 advisory, cor enable clear
    '{5'd25,0,1,0, 0,0,1, 1,1,1,1,0, 0,0,1, 4'b0100, 1,1, 2'd2}, // R9 fatal ignores advisory
    '{5'd26,0,1,1, 0,0,0, 1,1,1,0,0, 0,1,1, 4'b1001, 1,0, 2'd0}  // R9 advisory UR blocked
  };

  int checks = 0, fails = 0;
  bit done = 0;
  logic [ERR_W-1:0] exp_cor, exp_unc;
  logic [3:0] exp_dev;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    err_valid = 0; err_status = '0; err_is_cor = 0; err_advisory = 0; err_is_ur = 0;
    cor_mask = '0; uncor_mask = '0; uncor_sev = '0;
    cmd_serr_en = 0; ctl_cor_en = 0; ctl_nonfatal_en = 0; ctl_fatal_en = 0; ctl_ur_en = 0;
    bus_num = '0; devfn = '0;
    hop_in_valid = 0; hop_in_sev = '0; hop_in_src = '0; bridge_serr_en = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    exp_cor = '0; exp_unc = '0; exp_dev = '0;
  endtask

  task automatic chk_status(input string tag);
    chk({tag, " cor_status"}, cor_status, exp_cor);
    chk({tag, " uncor_status"}, uncor_status, exp_unc);
    chk({tag, " dev_status"}, {28'd0, dev_status}, {28'd0, exp_dev});
  endtask

  initial begin
    rst_n = 0;
    idle_inputs();
    do_reset();
    // R1 reset state
    chk("R1 log_req", log_req, 0);
    chk("R1 msg_valid", msg_valid, 0);
    chk("R1 sec_rcv_serr", sec_rcv_serr, 0);
    chk("R1 hop_out_valid", hop_out_valid, 0);
    chk_status("R1");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = VECS[i];
      @(negedge clk);
      err_status = ERR_W'(1) << v.idx;
      err_is_cor = v.cor; err_advisory = v.adv; err_is_ur = v.ur;
      cor_mask = {ERR_W{v.cm}}; uncor_mask = {ERR_W{v.um}}; uncor_sev = {ERR_W{v.sv}};
      ctl_cor_en = v.ce; ctl_nonfatal_en = v.ne; ctl_fatal_en = v.fe;
      ctl_ur_en = v.ue; cmd_serr_en = v.se;
      bus_num = 8'h30 + 8'(i); devfn = 8'(i * 8 + 3);
      err_valid = 1;
      @(negedge clk);
      err_valid = 0;
      if (v.x_cor) exp_cor |= ERR_W'(1) << v.idx;
      if (v.x_adv) exp_cor |= ERR_W'(1) << ADV;
      if (v.x_unc) exp_unc |= ERR_W'(1) << v.idx;
      exp_dev |= v.x_dev;
      chk($sformatf("R6 log row %0d", i), log_req, v.x_log);
      chk($sformatf("R7 msg row %0d", i), msg_valid, v.x_msg);
      if (v.x_msg) begin
        chk($sformatf("R5 sev row %0d", i), msg_sev, v.x_sev);
        chk($sformatf("R10 src row %0d", i), msg_src, {8'h30 + 8'(i), 8'(i * 8 + 3)});
      end
      chk_status($sformatf("R13 row %0d", i));
      @(negedge clk);
      chk($sformatf("R11 pulse row %0d", i), {30'd0, log_req, msg_valid}, 0);
    end

    // R2 invalid strobes: zero and two bits
    @(negedge clk);
    err_status = '0; err_is_cor = 0; uncor_sev = '0; ctl_nonfatal_en = 1; cmd_serr_en = 1;
    err_valid = 1;
    @(negedge clk);
    err_status = 32'h0000_0300; err_is_cor = 1; ctl_cor_en = 1;
    chk("R2 zero log", log_req, 0);
    chk("R2 zero msg", msg_valid, 0);
    @(negedge clk);
    err_valid = 0;
    chk("R2 multi msg", msg_valid, 0);
    chk("R2 multi log", log_req, 0);
    chk_status("R2");

    // R12 bridge hop
    do_reset();
    @(negedge clk);
    hop_in_valid = 1; hop_in_sev = 2'd0; hop_in_src = 16'hA1B2; bridge_serr_en = 1;
    @(negedge clk);
    hop_in_valid = 0;
    chk("R12 cor fwd valid", hop_out_valid, 1);
    chk("R12 cor fwd sev", hop_out_sev, 0);
    chk("R12 cor fwd src", hop_out_src, 16'hA1B2);
    chk("R12 cor no rcv", sec_rcv_serr, 0);
    @(negedge clk);
    hop_in_valid = 1; hop_in_sev = 2'd1; hop_in_src = 16'h0C0D; bridge_serr_en = 0;
    @(negedge clk);
    hop_in_valid = 0;
    chk("R12 blocked fwd", hop_out_valid, 0);
    chk("R12 nonfatal rcv", sec_rcv_serr, 1);

    // Same cycle: own error and fatal hop message
    @(negedge clk);
    err_status = ERR_W'(1) << 1; err_is_cor = 1; err_advisory = 0; err_is_ur = 0;
    cor_mask = '0; ctl_cor_en = 1; bus_num = 8'h5A; devfn = 8'h11;
    hop_in_valid = 1; hop_in_sev = 2'd2; hop_in_src = 16'h7788; bridge_serr_en = 1;
    err_valid = 1;
    @(negedge clk);
    err_valid = 0; hop_in_valid = 0;
    exp_cor |= ERR_W'(1) << 1; exp_dev |= 4'b0001;
    chk("R4 same-cycle msg", msg_valid, 1);
    chk("R4 same-cycle sev", msg_sev, 0);
    chk("R10 same-cycle src", msg_src, 16'h5A11);
    chk("R12 same-cycle fwd", hop_out_valid, 1);
    chk("R12 same-cycle fwd sev", hop_out_sev, 2);
    chk("R13 same-cycle rcv", sec_rcv_serr, 1);
    chk_status("R3 same-cycle");
    @(negedge clk);
    chk("R11 hop pulse", hop_out_valid, 0);

    // R1 reset clears all sticky state
    do_reset();
    chk("R1 rcv cleared", sec_rcv_serr, 0);
    chk_status("R1 after");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule